// File: doc/BRIEF.md
# Rotating-Top Register Stack File

This block keeps eight 80-bit entries that are addressed relative to a moving top-of-stack pointer. Entry st(0) is always the current top, and st(i) is the entry i places below it. The physical slot behind st(i) is the top pointer plus i, taken modulo eight. Software-visible operations come in as single commands: load a new top, drop the top, swap the top with any entry, add or subtract with the top as one operand, and empty the whole stack. Each physical slot carries a tag that says whether it holds a live value. Commands that would overwrite a live slot or read a dead one are refused, and a one-cycle status pulse reports the refusal.

The arithmetic is plain 80-bit two's-complement add and subtract, wrapping modulo 2^80. This lets the stack mechanics be exercised without a floating-point datapath. Commands travel on a valid/ready port. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high, and it completes in that same edge. `cmd_ready` is low while reset is asserted and for the edge on which reset is released. After that it stays high, so back-pressure only ever comes from reset. While `cmd_valid` is high and `cmd_ready` is low, the source must hold the command steady. The current top and its tag can be read at any time on the read port.

Top module: `rstk_file`

## Requirements
- R1: After reset, every tag is empty and the top pointer is 0. `top_valid`, `overflow` and `underflow` are all 0.
- R2: An accepted push (opcode 1) of D decrements the top pointer modulo 8 and writes D into the new top. From the next cycle, `top_data` is D and `top_valid` is 1, and the previous top is now st(1).
- R3: A push whose target slot (st(7) before the push) is already live is refused. `overflow` is 1 for exactly the following cycle and no entry, tag or pointer changes. `overflow` and `underflow` are never 1 together.
- R4: An accepted pop (opcode 2) empties the top slot and increments the pointer, so the old st(1) becomes st(0). A pop of an empty top is refused with `underflow`.
- R5: Exchange (opcode 3) swaps st(0) and st(i) in one command, where i is `cmd_idx`.
- R6: Add (opcode 4) with `cmd_dir`=0 writes st(0)+st(i) into st(0). With `cmd_dir`=1 it writes st(i)+st(0) into st(i).
- R7: Subtract (opcode 5) computes destination minus source. Reversed subtract (opcode 6) computes source minus destination. The destination is st(0) when `cmd_dir`=0 and st(i) when `cmd_dir`=1, and the other operand is the source. Results wrap modulo 2^80.
- R8: With `cmd_pop`=1, an arithmetic command writes its result and then pops. For example, add with `cmd_dir`=1, i=1 and pop leaves st(1)+st(0) at the new top. On push and exchange, `cmd_pop` has no effect.
- R9: Exchange or arithmetic where st(0) or st(i) is empty is refused. `underflow` is 1 for the next cycle and the state is unchanged.
- R10: Clear (opcode 7) empties all eight tags and sets the pointer to 0. After a clear, eight pushes succeed and a ninth overflows.
- R11: `cmd_ready` is 0 during reset and 1 from the first edge after reset onward. A cycle with `cmd_valid`=0, or a no-op (opcode 0), changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | A command is accepted this edge if offered |
| cmd_op | input | 3 | Opcode: 0 nop, 1 push, 2 pop, 3 exchange, 4 add, 5 sub, 6 reversed sub, 7 clear |
| cmd_idx | input | 3 | Relative index i of the second operand st(i) |
| cmd_dir | input | 1 | 0: result into st(0); 1: result into st(i) |
| cmd_pop | input | 1 | Pop after an arithmetic command |
| push_data | input | 80 | Value loaded by a push |
| top_data | output | 80 | Contents of st(0) |
| top_valid | output | 1 | Tag of st(0) |
| overflow | output | 1 | One-cycle pulse: a push was refused |
| underflow | output | 1 | One-cycle pulse: an empty entry was popped or read |

## Verification
The checker watches several properties on every cycle. A refused command leaves the top value, its tag and the pointer untouched. The two status pulses are never high together. Each accepted push or pop moves the pointer by exactly one step. A clear leaves an empty top at pointer 0, and no-ops leave everything as it was. The bench scenarios are the only evidence for the actual values deeper in the stack. These include the order in which eight pushed values come back, the results of the add, subtract and reversed-subtract variants in both directions, wraparound of subtraction, and the pop-after-operate variant leaving its result on the new top. They also cover exchange with a deep entry and the fact that clearing really frees all eight slots.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_XCHG  = 3'd3,
    OP_ADD   = 3'd4,
    OP_SUB   = 3'd5,
    OP_SUBR  = 3'd6,
    OP_CLEAR = 3'd7
  } rstk_op_e;

  typedef enum logic [1:0] {
    FN_ADD  = 2'd0,
    FN_SUB  = 2'd1,
    FN_SUBR = 2'd2
  } rstk_fn_e;
endpackage

// File: rtl/rstk_ptr.sv
module rstk_ptr #(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_down,
  input  logic             step_up,
  input  logic             zero,
  output logic [PTR_W-1:0] top
);
  always_ff @(posedge clk) begin
    if (rst || zero) begin
      top <= '0;
    end else if (step_down) begin
      top <= top - 1'b1;
    end else if (step_up) begin
      top <= top + 1'b1;
    end
  end
endmodule

// File: rtl/rstk_alu.sv
module rstk_alu
  import rstk_pkg::*;
#(
  parameter int DATA_W = 80
) (
  input  rstk_fn_e          fn,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    case (fn)
      FN_SUB:  res = dst - src;
      FN_SUBR: res = src - dst;
      default: res = dst + src;
    endcase
  end
endmodule

// File: rtl/rstk_regs.sv
module rstk_regs #(
  parameter int DATA_W = 80,
  parameter int DEPTH  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wa_en,
  input  logic [$clog2(DEPTH)-1:0] wa_addr,
  input  logic [DATA_W-1:0]        wa_data,
  input  logic                     wb_en,
  input  logic [$clog2(DEPTH)-1:0] wb_addr,
  input  logic [DATA_W-1:0]        wb_data,
  input  logic                     kill_en,
  input  logic [$clog2(DEPTH)-1:0] kill_addr,
  input  logic                     kill_all,
  input  logic [$clog2(DEPTH)-1:0] rd0_addr,
  input  logic [$clog2(DEPTH)-1:0] rd1_addr,
  output logic [DATA_W-1:0]        rd0_data,
  output logic [DATA_W-1:0]        rd1_data,
  output logic [DEPTH-1:0]         tags
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic hit_a, hit_b, hit_k;
    assign hit_a = wa_en   && (wa_addr   == AW'(e));
    assign hit_b = wb_en   && (wb_addr   == AW'(e));
    assign hit_k = kill_en && (kill_addr == AW'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        mem[e] <= '0;
      end else if (hit_a) begin
        mem[e] <= wa_data;
      end else if (hit_b) begin
        mem[e] <= wb_data;
      end
    end

    // an empty-mark beats a write in the same cycle (operate-then-pop on st(0))
    always_ff @(posedge clk) begin
      if (rst || kill_all) begin
        tags[e] <= 1'b0;
      end else if (hit_k) begin
        tags[e] <= 1'b0;
      end else if (hit_a || hit_b) begin
        tags[e] <= 1'b1;
      end
    end
  end

  assign rd0_data = mem[rd0_addr];
  assign rd1_data = mem[rd1_addr];
endmodule

// File: rtl/rstk_file.sv
module rstk_file
  import rstk_pkg::*;
#(
  parameter int DATA_W = 80,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [2:0]        cmd_idx,
  input  logic              cmd_dir,
  input  logic              cmd_pop,
  input  logic [DATA_W-1:0] push_data,
  output logic [DATA_W-1:0] top_data,
  output logic              top_valid,
  output logic              overflow,
  output logic              underflow
);
  // DEPTH must be a power of two so that pointer arithmetic wraps modulo DEPTH
  localparam int PTR_W = $clog2(DEPTH);

  rstk_op_e           op;
  logic               take;
  logic [PTR_W-1:0]   top_idx;
  logic [PTR_W-1:0]   ph_top, ph_rel, ph_new;
  logic [DEPTH-1:0]   tags;
  logic [DATA_W-1:0]  d_top, d_rel;
  logic               live_top, live_rel, live_new;

  logic               wa_en, wb_en, kill_en, kill_all;
  logic [PTR_W-1:0]   wa_addr, wb_addr, kill_addr;
  logic [DATA_W-1:0]  wa_data, wb_data;
  logic               p_down, p_up, p_zero;
  logic               ovf_d, unf_d;

  rstk_fn_e           fn;
  logic [DATA_W-1:0]  alu_dst, alu_src, alu_res;

  assign op   = rstk_op_e'(cmd_op);
  assign take = cmd_valid && cmd_ready;

  assign ph_top = top_idx;
  assign ph_rel = top_idx + PTR_W'(cmd_idx);
  assign ph_new = top_idx - 1'b1;

  assign live_top = tags[ph_top];
  assign live_rel = tags[ph_rel];
  assign live_new = tags[ph_new];

  rstk_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .step_down (p_down),
    .step_up   (p_up),
    .zero      (p_zero),
    .top       (top_idx)
  );

  rstk_regs #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wa_en     (wa_en),
    .wa_addr   (wa_addr),
    .wa_data   (wa_data),
    .wb_en     (wb_en),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data),
    .kill_en   (kill_en),
    .kill_addr (kill_addr),
    .kill_all  (kill_all),
    .rd0_addr  (ph_top),
    .rd1_addr  (ph_rel),
    .rd0_data  (d_top),
    .rd1_data  (d_rel),
    .tags      (tags)
  );

  always_comb begin
    case (op)
      OP_SUB:  fn = FN_SUB;
      OP_SUBR: fn = FN_SUBR;
      default: fn = FN_ADD;
    endcase
    alu_dst = cmd_dir ? d_rel : d_top;
    alu_src = cmd_dir ? d_top : d_rel;
  end

  rstk_alu #(.DATA_W(DATA_W)) u_alu (
    .fn  (fn),
    .dst (alu_dst),
    .src (alu_src),
    .res (alu_res)
  );

  always_comb begin
    wa_en     = 1'b0;
    wa_addr   = ph_top;
    wa_data   = push_data;
    wb_en     = 1'b0;
    wb_addr   = ph_rel;
    wb_data   = d_top;
    kill_en   = 1'b0;
    kill_addr = ph_top;
    kill_all  = 1'b0;
    p_down    = 1'b0;
    p_up      = 1'b0;
    p_zero    = 1'b0;
    ovf_d     = 1'b0;
    unf_d     = 1'b0;
    if (take) begin
      case (op)
        OP_PUSH: begin
          if (live_new) begin
            ovf_d = 1'b1;
          end else begin
            wa_en   = 1'b1;
            wa_addr = ph_new;
            wa_data = push_data;
            p_down  = 1'b1;
          end
        end
        OP_POP: begin
          if (!live_top) begin
            unf_d = 1'b1;
          end else begin
            kill_en = 1'b1;
            p_up    = 1'b1;
          end
        end
        OP_XCHG: begin
          if (!(live_top && live_rel)) begin
            unf_d = 1'b1;
          end else begin
            wa_en   = 1'b1;
            wa_addr = ph_top;
            wa_data = d_rel;
            wb_en   = 1'b1;
            wb_addr = ph_rel;
            wb_data = d_top;
          end
        end
        OP_ADD, OP_SUB, OP_SUBR: begin
          if (!(live_top && live_rel)) begin
            unf_d = 1'b1;
          end else begin
            wa_en   = 1'b1;
            wa_addr = cmd_dir ? ph_rel : ph_top;
            wa_data = alu_res;
            if (cmd_pop) begin
              kill_en = 1'b1;
              p_up    = 1'b1;
            end
          end
        end
        OP_CLEAR: begin
          kill_all = 1'b1;
          p_zero   = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
      cmd_ready <= 1'b0;
    end else begin
      overflow  <= ovf_d;
      underflow <= unf_d;
      cmd_ready <= 1'b1;
    end
  end

  assign top_data  = d_top;
  assign top_valid = live_top;
endmodule

// File: rtl/rstk_file_chk.sv
module rstk_file_chk #(
  parameter int DATA_W = 80,
  parameter int PTR_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [DATA_W-1:0] push_data,
  input logic [DATA_W-1:0] top_data,
  input logic              top_valid,
  input logic              overflow,
  input logic              underflow,
  input logic [PTR_W-1:0]  top_idx
);
  logic take;
  assign take = cmd_valid && cmd_ready;

  assert_ready_stays_R11: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |=> cmd_ready);

  assert_flags_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(overflow && underflow));

  assert_no_overflow_change_R3: assert property (@(posedge clk) disable iff (rst)
    overflow |-> ($stable(top_data) && $stable(top_idx) && $stable(top_valid)));

  assert_no_underflow_change_R9: assert property (@(posedge clk) disable iff (rst)
    underflow |-> ($stable(top_data) && $stable(top_idx) && $stable(top_valid)));

  assert_push_top_R2: assert property (@(posedge clk) disable iff (rst)
    (take && cmd_op == 3'd1) |=>
      (overflow || (top_valid && top_data == $past(push_data))));

  assert_push_ptr_R2: assert property (@(posedge clk) disable iff (rst)
    (take && cmd_op == 3'd1) |=>
      (overflow || top_idx == $past(top_idx) - 1'b1));

  assert_pop_ptr_R4: assert property (@(posedge clk) disable iff (rst)
    (take && cmd_op == 3'd2) |=>
      (underflow || top_idx == $past(top_idx) + 1'b1));

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (take && cmd_op == 3'd7) |=>
      (!top_valid && top_idx == '0 && !overflow && !underflow));

  assert_nop_R11: assert property (@(posedge clk) disable iff (rst)
    (!take || cmd_op == 3'd0) |=>
      ($stable(top_data) && $stable(top_idx) && $stable(top_valid) && !overflow && !underflow));
endmodule

bind rstk_file rstk_file_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .push_data (push_data),
  .top_data  (top_data),
  .top_valid (top_valid),
  .overflow  (overflow),
  .underflow (underflow),
  .top_idx   (top_idx)
);

// File: tb/rstk_file_bench.sv
`timescale 1ns/1ps
module rstk_file_bench;
  localparam int W = 80;
  localparam logic [2:0] NOP = 3'd0, PUSH = 3'd1, POP = 3'd2, XCHG = 3'd3,
                         ADD = 3'd4, SUB = 3'd5, SUBR = 3'd6, CLR = 3'd7;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [2:0]   cmd_op = NOP;
  logic [2:0]   cmd_idx = '0;
  logic         cmd_dir = 1'b0;
  logic         cmd_pop = 1'b0;
  logic [W-1:0] push_data = '0;
  logic [W-1:0] top_data;
  logic         top_valid, overflow, underflow;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rstk_file u_rstk_file (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_idx   (cmd_idx),
    .cmd_dir   (cmd_dir),
    .cmd_pop   (cmd_pop),
    .push_data (push_data),
    .top_data  (top_data),
    .top_valid (top_valid),
    .overflow  (overflow),
    .underflow (underflow)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // offers one command on a falling edge; returns on the next falling edge
  task automatic send(input logic [2:0] op, input logic [2:0] idx, input logic dir,
                      input logic pf, input logic [W-1:0] d);
    @(negedge clk);
    cmd_op = op; cmd_idx = idx; cmd_dir = dir; cmd_pop = pf; push_data = d;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = NOP;
  endtask

  task automatic push(input logic [W-1:0] d);
    send(PUSH, 3'd0, 1'b0, 1'b0, d);
  endtask

  task automatic t_reset_R1;
    chk("R11 ready low in reset", W'(cmd_ready), W'(0));
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 top_valid after reset", W'(top_valid), W'(0));
    chk("R1 overflow after reset", W'(overflow), W'(0));
    chk("R1 underflow after reset", W'(underflow), W'(0));
    chk("R11 ready after reset", W'(cmd_ready), W'(1));
  endtask

  task automatic t_push_pop_R2_R4;
    send(CLR, 0, 0, 0, 0);
    push(80'hA1); push(80'hB2);
    chk("R2 top after push", top_data, 80'hB2);
    chk("R2 top_valid", W'(top_valid), W'(1));
    send(POP, 0, 0, 0, 0);
    chk("R4 old st1 now top", top_data, 80'hA1);
    send(POP, 0, 0, 0, 0);
    chk("R4 empty after pops", W'(top_valid), W'(0));
    send(POP, 0, 0, 0, 0);
    chk("R4 pop empty underflow", W'(underflow), W'(1));
    chk("R4 still empty", W'(top_valid), W'(0));
  endtask

  task automatic t_overflow_R3;
    send(CLR, 0, 0, 0, 0);
    for (int k = 0; k < 8; k++) begin
      push(W'(100 + k));
      chk("R3 no overflow within 8", W'(overflow), W'(0));
    end
    push(80'hDEAD);
    chk("R3 ninth push overflows", W'(overflow), W'(1));
    chk("R3 top unchanged", top_data, W'(107));
    @(negedge clk);
    chk("R3 overflow one cycle", W'(overflow), W'(0));
    for (int k = 7; k >= 0; k--) begin
      chk("R4 pop order", top_data, W'(100 + k));
      send(POP, 0, 0, 0, 0);
    end
    chk("R4 empty after 8 pops", W'(top_valid), W'(0));
  endtask

  task automatic t_xchg_R5;
    send(CLR, 0, 0, 0, 0);
    push(10); push(20); push(30);
    send(XCHG, 3'd2, 0, 1, 0);
    chk("R5 exchange brings st2", top_data, W'(10));
    chk("R8 pop flag ignored on exchange", W'(top_valid), W'(1));
    send(POP, 0, 0, 0, 0);
    chk("R5 st1 intact", top_data, W'(20));
    send(POP, 0, 0, 0, 0);
    chk("R5 old top moved down", top_data, W'(30));
  endtask

  task automatic t_add_R6;
    send(CLR, 0, 0, 0, 0);
    push(5); push(7);
    send(ADD, 3'd1, 0, 0, 0);
    chk("R6 add into st0", top_data, W'(12));
    send(POP, 0, 0, 0, 0);
    chk("R6 st1 untouched", top_data, W'(5));
    push(100);
    send(ADD, 3'd1, 1, 0, 0);
    chk("R6 dir=1 keeps st0", top_data, W'(100));
    send(POP, 0, 0, 0, 0);
    chk("R6 add into st1", top_data, W'(105));
  endtask

  task automatic t_sub_R7;
    send(CLR, 0, 0, 0, 0);
    push(3); push(10);
    send(SUB, 3'd1, 0, 0, 0);
    chk("R7 sub st0-st1", top_data, W'(7));
    send(SUBR, 3'd1, 0, 0, 0);
    chk("R7 reversed sub wraps", top_data, 80'hFFFF_FFFF_FFFF_FFFF_FFFC);
    send(SUBR, 3'd1, 1, 0, 0);
    send(POP, 0, 0, 0, 0);
    chk("R7 reversed sub into st1", top_data, 80'hFFFF_FFFF_FFFF_FFFF_FFF9);
  endtask

  task automatic t_popafter_R8;
    send(CLR, 0, 0, 0, 0);
    push(2); push(9);
    send(ADD, 3'd1, 1, 1, 0);
    chk("R8 result at new top", top_data, W'(11));
    chk("R8 new top valid", W'(top_valid), W'(1));
    send(POP, 0, 0, 0, 0);
    chk("R8 depth reduced by one", W'(top_valid), W'(0));
  endtask

  task automatic t_underflow_R9;
    send(CLR, 0, 0, 0, 0);
    push(4);
    send(ADD, 3'd3, 0, 1, 0);
    chk("R9 empty operand underflow", W'(underflow), W'(1));
    chk("R9 top unchanged", top_data, W'(4));
    send(XCHG, 3'd5, 0, 0, 0);
    chk("R9 exchange with empty", W'(underflow), W'(1));
    send(POP, 0, 0, 0, 0);
    chk("R9 depth unchanged", W'(top_valid), W'(0));
  endtask

  task automatic t_clear_R10;
    push(1); push(2); push(3);
    send(CLR, 0, 0, 0, 0);
    chk("R10 clear empties top", W'(top_valid), W'(0));
    for (int k = 0; k < 8; k++) push(W'(k));
    chk("R10 eight pushes fit", W'(overflow), W'(0));
    push(99);
    chk("R10 ninth overflows", W'(overflow), W'(1));
  endtask

  task automatic t_idle_R11;
    send(CLR, 0, 0, 0, 0);
    push(55);
    @(negedge clk);
    cmd_op = PUSH; push_data = 80'h77; cmd_valid = 1'b0;
    @(negedge clk);
    cmd_op = NOP;
    chk("R11 unoffered push ignored", top_data, W'(55));
    send(NOP, 3'd1, 1, 1, 80'h66);
    chk("R11 nop no change", top_data, W'(55));
    send(POP, 0, 0, 0, 0);
    chk("R11 depth still one", W'(top_valid), W'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_R1();
    t_push_pop_R2_R4();
    t_overflow_R3();
    t_xchg_R5();
    t_add_R6();
    t_sub_R7();
    t_popafter_R8();
    t_underflow_R9();
    t_clear_R10();
    t_idle_R11();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule